// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of which event produced the most recent reset of the processor. Seven reset sources each deliver a one-cycle pulse: power-on, the external reset pin, watchdog timeout, illegal opcode, an opcode fetch from an unimplemented address, monitor-mode entry, and low-voltage inhibit. Each pulse latches a flag. Flags from different sources accumulate until software reads them. A power-on event replaces all history with the power-on flag alone. Monitor-mode entry happens when both reset vector bytes at the top of memory are erased (0xFF) after power-on while the IRQ pin is not at the test voltage.

Software reads the flags through an 8-bit bus read port. A read clears the flags it returned. A second register holds one break-clear enable bit. While the processor is halted for debug, a read clears the flags only when that bit is set. With the bit clear, a debugger can inspect the flags without destroying them. Read data is registered. The clear takes effect one cycle after the read strobe, so the returned byte always shows the flags as they stood before clearing.

Top module: `rst_cause_regs`

## Requirements
- R1: The status byte holds power-on in bit 7, pin in bit 6, watchdog in bit 5, illegal opcode in bit 4, illegal address in bit 3, monitor entry in bit 2 and low-voltage in bit 1. Bit 0 reads 0. Input `cause_pulse[i]` drives status bit i+1.
- R2: While `por_n` is low, and after it is released with no other activity, the status byte reads 0x80, the break-clear enable reads 0, and `bus_rdata` is 0.
- R3: A pulse from any source other than power-on sets that source's flag and leaves all other flags unchanged. No flag rises without a pulse.
- R4: A power-on pulse sets the power-on flag and clears every flag not pulsed in the same cycle.
- R5: A status read returns the flags on `bus_rdata` in the following cycle, before any clearing. The returned flags are then cleared, so an immediate second read with no new events returns 0x00.
- R6: A reset pulse arriving in the same cycle as a status read, or in the cycle the clear is applied, leaves its flag set.
- R7: With `in_break` high during the read cycle, a status read clears the flags only if the break-clear enable is 1. Otherwise the flags are kept.
- R8: The break control register has a read/write enable in bit 7. Bits 6 to 0 read 0 and ignore writes.
- R9: Any reset pulse clears the break-clear enable. This takes precedence over a write in the same cycle.
- R10: Writes to the status register address have no effect on the flags.
- R11: In a cycle with no read of either mapped address, `bus_rdata` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-up initialisation, active low |
| cause_pulse | input | 7 | One-cycle reset source pulses; bit 6 power-on down to bit 0 low-voltage |
| in_break | input | 1 | Processor halted in a debug break |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after the strobe |

## Verification
The bench targets these corner cases:
- **Event during a read or a clear.** It places events in the exact cycle of a read and in the cycle the delayed clear lands. A design that cleared with a stale mask would lose a reset cause that software never saw.
- **Power-on mixed with other events.** It combines power-on with other pending flags. A design that merged power-on like any other source would report several causes at once.
- **Reads during a break.** It reads while halted with the enable at 0 and at 1. A design that ignored the gate would wipe the flags under a debugger.
- **Write racing an event.** It sets the enable in the same cycle as a reset pulse. A design that let the write win would leave clearing enabled after a reset.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FLAG_N  = 7;
  localparam int unsigned POR_IDX = FLAG_N - 1;
  localparam int unsigned PAD_W   = DATA_W - FLAG_N;

  typedef logic [FLAG_N-1:0] flag_vec_t;
  typedef logic [DATA_W-1:0] byte_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STS  = 2'd1,
    SEL_BRK  = 2'd2
  } sel_e;

  localparam flag_vec_t POWERUP_FLAGS = flag_vec_t'(1) << POR_IDX;

  // Next held flags: power-on replaces the history, others accumulate.
  function automatic flag_vec_t flag_update(flag_vec_t held, flag_vec_t pend,
                                            flag_vec_t pulse);
    if (pulse[POR_IDX]) return pulse;
    return (held & ~pend) | pulse;
  endfunction

  // Bits to drop one cycle after a clearing read; a fresh pulse is spared.
  function automatic flag_vec_t clear_mask(flag_vec_t vis, flag_vec_t pulse,
                                           logic take);
    return take ? (vis & ~pulse) : '0;
  endfunction

  function automatic logic clear_allowed(logic halted, logic en);
    return !halted || en;
  endfunction

  function automatic byte_t sts_byte(flag_vec_t v);
    return {v, {PAD_W{1'b0}}};
  endfunction

  function automatic byte_t brk_byte(logic en);
    return {en, {(DATA_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/rcs_flag_store.sv
module rcs_flag_store
  import rcs_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  flag_vec_t cause_pulse,
  input  logic      take_snapshot,
  output flag_vec_t vis_flags,
  output flag_vec_t pend_mask
);
  flag_vec_t held_q;
  flag_vec_t pend_q;

  assign vis_flags = held_q & ~pend_q;
  assign pend_mask = pend_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      held_q <= POWERUP_FLAGS;
      pend_q <= '0;
    end else begin
      held_q <= flag_update(held_q, pend_q, cause_pulse);
      pend_q <= clear_mask(vis_flags, cause_pulse, take_snapshot);
    end
  end
endmodule

// File: rtl/rcs_brk_ctl.sv
module rcs_brk_ctl (
  input  logic clk,
  input  logic por_n,
  input  logic wr_hit,
  input  logic wr_bit,
  input  logic any_event,
  output logic en
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         en <= 1'b0;
    else if (any_event) en <= 1'b0;
    else if (wr_hit)    en <= wr_bit;
  end
endmodule

// File: rtl/rcs_bus_port.sv
module rcs_bus_port
  import rcs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR = 'h01,
  parameter logic [ADDR_W-1:0] BRK_ADDR = 'h0E
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  flag_vec_t         vis_flags,
  input  logic              brk_en,
  output logic              sts_rd,
  output logic              brk_rd,
  output logic              brk_wr,
  output byte_t             rdata
);
  sel_e sel;

  always_comb begin
    if (bus_addr == STS_ADDR)      sel = SEL_STS;
    else if (bus_addr == BRK_ADDR) sel = SEL_BRK;
    else                           sel = SEL_NONE;
  end

  assign sts_rd = bus_rd && (sel == SEL_STS);
  assign brk_rd = bus_rd && (sel == SEL_BRK);
  assign brk_wr = bus_wr && (sel == SEL_BRK);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      rdata <= '0;
    else if (sts_rd) rdata <= sts_byte(vis_flags);
    else if (brk_rd) rdata <= brk_byte(brk_en);
    else             rdata <= '0;
  end
endmodule

// File: rtl/rst_cause_regs.sv
module rst_cause_regs
  import rcs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR = 'h01,
  parameter logic [ADDR_W-1:0] BRK_ADDR = 'h0E
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [6:0]        cause_pulse,
  input  logic              in_break,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  // Named internal events, observed by the bound checker.
  flag_vec_t vis_flags;
  flag_vec_t pend_mask;
  logic      sts_rd;
  logic      brk_rd;
  logic      brk_wr;
  logic      brk_en;
  logic      any_event;
  logic      take_snapshot;
  logic      unused_wdata_lo;

  assign any_event       = |cause_pulse;
  assign take_snapshot   = sts_rd && clear_allowed(in_break, brk_en);
  assign unused_wdata_lo = ^bus_wdata[DATA_W-2:0];

  rcs_flag_store u_store (
    .clk           (clk),
    .por_n         (por_n),
    .cause_pulse   (cause_pulse),
    .take_snapshot (take_snapshot),
    .vis_flags     (vis_flags),
    .pend_mask     (pend_mask)
  );

  rcs_brk_ctl u_brk (
    .clk       (clk),
    .por_n     (por_n),
    .wr_hit    (brk_wr),
    .wr_bit    (bus_wdata[DATA_W-1]),
    .any_event (any_event),
    .en        (brk_en)
  );

  rcs_bus_port #(
    .ADDR_W   (ADDR_W),
    .STS_ADDR (STS_ADDR),
    .BRK_ADDR (BRK_ADDR)
  ) u_bus (
    .clk       (clk),
    .por_n     (por_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .vis_flags (vis_flags),
    .brk_en    (brk_en),
    .sts_rd    (sts_rd),
    .brk_rd    (brk_rd),
    .brk_wr    (brk_wr),
    .rdata     (bus_rdata)
  );
endmodule

// File: rtl/rcs_chk.sv
module rcs_chk
  import rcs_pkg::*;
(
  input logic      clk,
  input logic      por_n,
  input flag_vec_t cause_pulse,
  input logic      in_break,
  input byte_t     bus_rdata,
  input logic      brk_en,
  input flag_vec_t vis_flags,
  input flag_vec_t pend_mask,
  input logic      sts_rd,
  input logic      brk_rd
);
  AST_LOW_BIT_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    sts_rd |=> (bus_rdata[0] == 1'b0)); // R1

  AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!por_n)
    (cause_pulse == '0) |=> ((vis_flags & ~$past(vis_flags)) == '0)); // R3

  AST_POR_WIPES: assert property (@(posedge clk) disable iff (!por_n)
    cause_pulse[POR_IDX] |=> ((vis_flags & ~$past(cause_pulse)) == '0)); // R4

  AST_READ_SNAPSHOT: assert property (@(posedge clk) disable iff (!por_n)
    sts_rd |=> (bus_rdata == sts_byte($past(vis_flags)))); // R5

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!por_n)
    (cause_pulse != '0) |=> ((vis_flags & $past(cause_pulse)) == $past(cause_pulse))); // R6

  AST_BREAK_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
    (sts_rd && in_break && !brk_en) |=> (pend_mask == '0)); // R7

  AST_BRK_RSVD_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    brk_rd |=> (bus_rdata[DATA_W-2:0] == '0)); // R8

  AST_EVENT_DROPS_EN: assert property (@(posedge clk) disable iff (!por_n)
    (cause_pulse != '0) |=> !brk_en); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    !(sts_rd || brk_rd) |=> (bus_rdata == '0)); // R11
endmodule

bind rst_cause_regs rcs_chk u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .cause_pulse (cause_pulse),
  .in_break    (in_break),
  .bus_rdata   (bus_rdata),
  .brk_en      (brk_en),
  .vis_flags   (vis_flags),
  .pend_mask   (pend_mask),
  .sts_rd      (sts_rd),
  .brk_rd      (brk_rd)
);

// File: tb/sim_rst_cause_regs.sv
`timescale 1ns/1ps
module sim_rst_cause_regs;
  localparam logic [7:0] STS = 8'h01;
  localparam logic [7:0] BRK = 8'h0E;
  localparam logic [7:0] NOWHERE = 8'h55;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic [6:0] cause_pulse = '0;
  logic       in_break = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [6:0] mf = 7'b1000000;
  logic       mb = 1'b0;

  always #2.5 clk = ~clk;

  rst_cause_regs #(.ADDR_W(8), .STS_ADDR(STS), .BRK_ADDR(BRK)) u0 (
    .clk(clk), .por_n(por_n), .cause_pulse(cause_pulse), .in_break(in_break),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Expected read byte from the model state before the cycle.
  function automatic logic [7:0] exp_read(logic rd, logic [7:0] a,
                                          logic [6:0] f, logic b);
    if (rd && a == STS) return {f, 1'b0};
    if (rd && a == BRK) return {b, 7'd0};
    return 8'h00;
  endfunction

  function automatic logic [6:0] next_flags(logic [6:0] f, logic clr,
                                            logic [6:0] p);
    logic [6:0] kept;
    kept = clr ? 7'd0 : f;
    if (p[6]) return p;
    return kept | p;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // One bus cycle, driven at a falling edge; result checked at the next one.
  task automatic step(logic rd, logic wr, logic [7:0] a, logic [7:0] wd,
                      logic [6:0] p, logic halted, string tag);
    logic [7:0] exp;
    logic clr;
    exp = exp_read(rd, a, mf, mb);
    clr = rd && (a == STS) && (!halted || mb);
    mf  = next_flags(mf, clr, p);
    if (p != 0) mb = 1'b0;
    else if (wr && a == BRK) mb = wd[7];
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    cause_pulse = p; in_break = halted;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; cause_pulse = '0; in_break = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic rd_sts(string tag);
    step(1'b1, 1'b0, STS, 8'h00, 7'd0, 1'b0, tag);
  endtask

  task automatic pulse(logic [6:0] p);
    step(1'b0, 1'b0, NOWHERE, 8'h00, p, 1'b0, "R11 idle");
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0007));
    @(negedge clk);
    check("R2 rdata in power-up", bus_rdata, 8'h00);
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R2 power-up state, R5 clear after read
    step(1'b1, 1'b0, BRK, 8'h00, 7'd0, 1'b0, "R2 brk after power-up");
    rd_sts("R2 status after power-up");
    rd_sts("R5 second read cleared");

    // R1 each source alone maps to bit i+1
    for (int i = 0; i < 6; i++) begin
      pulse(7'(1) << i);
      rd_sts("R1 bit layout");
    end

    // R3 accumulate without power-on
    pulse(7'b0100000);
    pulse(7'b0010000);
    rd_sts("R3 pin plus watchdog");

    // R4 power-on wipes others
    pulse(7'b0000001);
    pulse(7'b0100000);
    pulse(7'b1000000);
    rd_sts("R4 power-on alone");

    // R6 event in read cycle and in clearing cycle
    step(1'b1, 1'b0, STS, 8'h00, 7'b0001000, 1'b0, "R6 read with event");
    rd_sts("R6 event kept after read");
    pulse(7'b0000010);
    rd_sts("R6 read before clear-cycle event");
    pulse(7'b0000100);
    rd_sts("R6 clear-cycle event kept");

    // R7 break gating
    pulse(7'b0000001);
    step(1'b1, 1'b0, STS, 8'h00, 7'd0, 1'b1, "R7 halted read enable 0");
    step(1'b1, 1'b0, STS, 8'h00, 7'd0, 1'b1, "R7 flags kept in break");
    step(1'b0, 1'b1, BRK, 8'h80, 7'd0, 1'b0, "R11 write cycle");
    step(1'b1, 1'b0, STS, 8'h00, 7'd0, 1'b1, "R7 halted read enable 1");
    rd_sts("R7 cleared in break");

    // R8 enable bit and reserved bits
    step(1'b0, 1'b1, BRK, 8'hFF, 7'd0, 1'b0, "R11 write cycle");
    step(1'b1, 1'b0, BRK, 8'h00, 7'd0, 1'b0, "R8 write ff reads 80");
    step(1'b0, 1'b1, BRK, 8'h7F, 7'd0, 1'b0, "R11 write cycle");
    step(1'b1, 1'b0, BRK, 8'h00, 7'd0, 1'b0, "R8 write 7f reads 00");

    // R9 event beats write
    step(1'b0, 1'b1, BRK, 8'h80, 7'b0000010, 1'b0, "R11 write cycle");
    step(1'b1, 1'b0, BRK, 8'h00, 7'd0, 1'b0, "R9 enable dropped");
    rd_sts("R9 flag from that event");

    // R10 status writes ignored
    pulse(7'b0000010);
    step(1'b0, 1'b1, STS, 8'h00, 7'd0, 1'b0, "R10 write cycle");
    step(1'b0, 1'b1, STS, 8'hFF, 7'd0, 1'b0, "R10 write cycle");
    rd_sts("R10 flags unchanged");

    // R11 unmapped read
    step(1'b1, 1'b0, NOWHERE, 8'h00, 7'd0, 1'b0, "R11 unmapped read");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic rd, wr, hb;
      logic [7:0] a, wd;
      logic [6:0] p;
      int sel, r;
      rd  = ($urandom % 3) == 0;
      wr  = ($urandom % 5) == 0;
      sel = $urandom % 5;
      a   = (sel < 2) ? STS : (sel < 4) ? BRK : 8'($urandom);
      wd  = 8'($urandom);
      hb  = ($urandom % 4) == 0;
      r   = $urandom % 16;
      p   = (r == 0) ? 7'(1) << ($urandom % 7) :
            (r == 1) ? 7'($urandom) & 7'b0111111 : 7'd0;
      step(rd, wr, a, wd, p, hb,
           (rd && a == STS) ? "R5 random status" :
           (rd && a == BRK) ? "R8 random brk" : "R11 random idle");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule